// File: doc/BRIEF.md
# Nx64 Framed Serial Receiver

This block takes a channelized serial line, made of a line clock, a frame-sync input and a data input, and recovers its time slots. A frame holds N slots of eight bits each. N is chosen at run time from 1 to 128, so a frame is 8 to 1024 line bits long. Every completed slot leaves the block as one byte with its slot index and a start-of-frame flag. A sync pulse must mark every frame, and a sticky error flag records any sync that is out of place or missing.

All logic runs on one system clock, which must be at least four times faster than the line clock. The line clock, sync and data pass through the same synchronizer chain. Edges of the line clock are then detected on the system clock. Sync and data can each be sampled on the rising or the falling line edge, chosen independently. A two-state framer, HUNT and RUN, counts bits and slots. HUNT → RUN is taken on a sync-marked bit. RUN → HUNT is taken when a frame boundary arrives without a sync mark. RUN → RUN with restart is taken when a sync mark appears away from a boundary.

Top module: `tdm_frame_rx`

## Requirements
- R1: After reset, slot_vld and frm_err are low. No slot is produced until a sync mark has been seen (HUNT state).
- R2: edge_sel[1] picks the sync sampling edge and edge_sel[0] picks the data sampling edge (0 = rising, 1 = falling). This gives four pairings: 00, 01, 10 and 11.
- R3: A low-to-high change between two successive sync samples marks frame bit 0 of slot 0. That bit is the first data sample taken at or after that sync sample. A sync held high for several line periods counts once.
- R4: Within a slot, the first bit received appears on slot_data[7] and the eighth bit received appears on slot_data[0].
- R5: After the eighth bit of a slot is sampled, slot_vld pulses for one system clock with slot_data and slot_idx. slot_sof is high with it exactly when slot_idx is 0.
- R6: The frame length is N = nslots_m1 + 1 slots. slot_idx runs 0 to N-1 and then restarts at 0. N = 1 and N = 128 are supported.
- R7: A sync mark on a bit that is not a frame boundary sets frm_err. The block drops the partial slot and starts a new frame at that bit.
- R8: A frame boundary without a sync mark sets frm_err. The block returns to HUNT and produces no slots until the next sync mark.
- R9: frm_err stays high until reset, even while later frames are clean.
- R10: slot_vld never stays high on two consecutive system clocks. Successive slot indices either increase by one or restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_sel | input | 2 | Sampling edge pairing: bit 1 for sync, bit 0 for data |
| nslots_m1 | input | 7 | Slots per frame minus one; hold stable while running |
| line_clk | input | 1 | Serial line clock |
| line_sync | input | 1 | Frame sync from the line |
| line_data | input | 1 | Serial data from the line |
| slot_vld | output | 1 | One-cycle strobe for a completed slot |
| slot_data | output | 8 | Slot byte; first received bit in bit 7 |
| slot_idx | output | 7 | Index of the slot within its frame |
| slot_sof | output | 1 | High with slot_vld for slot 0 |
| frm_err | output | 1 | Sticky framing error flag |

## Verification
A bit counter that is off by one shows up at the ports within one slot. The next byte comes out rotated, and from then on every byte differs from the reference. A wrong slot counter or wrong frame-length compare shows up at the first wrap, as an index that does not restart at 0 and a missing start-of-frame flag. It also sets frm_err on the next sync, because the boundary falls in the wrong place. A wrong HUNT/RUN decision shows up within one frame: either slots appear with no sync behind them, or a run of expected slots is missing.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int SLOT_BITS = 8;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    // bit 1: sync edge, bit 0: data edge; 0 = rising, 1 = falling
    typedef enum logic [1:0] {
        EDGE_SR_DR = 2'b00,
        EDGE_SR_DF = 2'b01,
        EDGE_SF_DR = 2'b10,
        EDGE_SF_DF = 2'b11
    } edge_cfg_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } framer_state_e;

endpackage

// File: rtl/lclk_edge_det.sv
module lclk_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_sync,
    input  logic line_data,
    output logic rise_evt,
    output logic fall_evt,
    output logic sync_s,
    output logic data_s
);

    logic [STAGES-1:0] clk_sr;
    logic [STAGES-1:0] syn_sr;
    logic [STAGES-1:0] dat_sr;
    logic              clk_last;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sr[g] <= 1'b0;
                    syn_sr[g] <= 1'b0;
                    dat_sr[g] <= 1'b0;
                end else begin
                    clk_sr[g] <= line_clk;
                    syn_sr[g] <= line_sync;
                    dat_sr[g] <= line_data;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sr[g] <= 1'b0;
                    syn_sr[g] <= 1'b0;
                    dat_sr[g] <= 1'b0;
                end else begin
                    clk_sr[g] <= clk_sr[g-1];
                    syn_sr[g] <= syn_sr[g-1];
                    dat_sr[g] <= dat_sr[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_last <= 1'b0;
        else        clk_last <= clk_sr[STAGES-1];
    end

    assign rise_evt = clk_sr[STAGES-1] & ~clk_last;
    assign fall_evt = ~clk_sr[STAGES-1] & clk_last;
    assign sync_s   = syn_sr[STAGES-1];
    assign data_s   = dat_sr[STAGES-1];

endmodule

// File: rtl/line_sampler.sv
module line_sampler
    import tdm_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] edge_sel,
    input  logic       rise_evt,
    input  logic       fall_evt,
    input  logic       sync_s,
    input  logic       data_s,
    output logic       bit_evt,
    output logic       bit_val,
    output logic       bit_mark
);

    edge_cfg_e cfg;
    logic      sync_evt;
    logic      sync_prev;
    logic      sync_hit;
    logic      pend;

    assign cfg      = edge_cfg_e'(edge_sel);
    assign sync_evt = cfg[1] ? fall_evt : rise_evt;
    assign bit_evt  = cfg[0] ? fall_evt : rise_evt;
    assign bit_val  = data_s;
    assign sync_hit = sync_evt & sync_s & ~sync_prev;
    assign bit_mark = bit_evt & (pend | sync_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev <= 1'b0;
            pend      <= 1'b0;
        end else begin
            if (sync_evt) sync_prev <= sync_s;
            if (bit_evt)       pend <= 1'b0;
            else if (sync_hit) pend <= 1'b1;
        end
    end

endmodule

// File: rtl/slot_framer.sv
module slot_framer
    import tdm_rx_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int IDX_W    = $clog2(MAX_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     nslots_m1,
    input  logic                 bit_evt,
    input  logic                 bit_val,
    input  logic                 bit_mark,
    output logic                 slot_vld,
    output logic [SLOT_BITS-1:0] slot_data,
    output logic [IDX_W-1:0]     slot_idx,
    output logic                 slot_sof,
    output logic                 frm_err
);

    framer_state_e        state, state_nx;
    logic [BIT_W-1:0]     bit_cnt;
    logic [IDX_W-1:0]     slot_cnt;
    logic [SLOT_BITS-2:0] shreg;
    logic                 at_bound;
    logic                 last_bit;

    assign at_bound = (bit_cnt == '0) && (slot_cnt == '0);
    assign last_bit = (bit_cnt == BIT_W'(SLOT_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (bit_evt && bit_mark)             state_nx = ST_RUN;
            ST_RUN:  if (bit_evt && !bit_mark && at_bound) state_nx = ST_HUNT;
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            slot_cnt  <= '0;
            shreg     <= '0;
            slot_vld  <= 1'b0;
            slot_data <= '0;
            slot_idx  <= '0;
            slot_sof  <= 1'b0;
            frm_err   <= 1'b0;
        end else begin
            slot_vld <= 1'b0;
            if (bit_evt) begin
                unique case (state)
                    ST_HUNT: begin
                        if (bit_mark) begin
                            shreg    <= {shreg[SLOT_BITS-3:0], bit_val};
                            bit_cnt  <= BIT_W'(1);
                            slot_cnt <= '0;
                        end
                    end
                    ST_RUN: begin
                        if (bit_mark && !at_bound) begin
                            frm_err  <= 1'b1;
                            shreg    <= {shreg[SLOT_BITS-3:0], bit_val};
                            bit_cnt  <= BIT_W'(1);
                            slot_cnt <= '0;
                        end else if (!bit_mark && at_bound) begin
                            frm_err  <= 1'b1;
                        end else begin
                            shreg   <= {shreg[SLOT_BITS-3:0], bit_val};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                slot_vld  <= 1'b1;
                                slot_data <= {shreg, bit_val};
                                slot_idx  <= slot_cnt;
                                slot_sof  <= (slot_cnt == '0);
                                if (slot_cnt >= nslots_m1) slot_cnt <= '0;
                                else                       slot_cnt <= slot_cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
    import tdm_rx_pkg::*;
#(
    parameter int MAX_SLOTS   = 128,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(MAX_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           edge_sel,
    input  logic [IDX_W-1:0]     nslots_m1,
    input  logic                 line_clk,
    input  logic                 line_sync,
    input  logic                 line_data,
    output logic                 slot_vld,
    output logic [SLOT_BITS-1:0] slot_data,
    output logic [IDX_W-1:0]     slot_idx,
    output logic                 slot_sof,
    output logic                 frm_err
);

    logic rise_evt, fall_evt, sync_s, data_s;
    logic bit_evt, bit_val, bit_mark;

    lclk_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clk  (line_clk),
        .line_sync (line_sync),
        .line_data (line_data),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .sync_s    (sync_s),
        .data_s    (data_s)
    );

    line_sampler u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_sel (edge_sel),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .sync_s   (sync_s),
        .data_s   (data_s),
        .bit_evt  (bit_evt),
        .bit_val  (bit_val),
        .bit_mark (bit_mark)
    );

    slot_framer #(.MAX_SLOTS(MAX_SLOTS)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .nslots_m1 (nslots_m1),
        .bit_evt   (bit_evt),
        .bit_val   (bit_val),
        .bit_mark  (bit_mark),
        .slot_vld  (slot_vld),
        .slot_data (slot_data),
        .slot_idx  (slot_idx),
        .slot_sof  (slot_sof),
        .frm_err   (frm_err)
    );

endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] nslots_m1,
    input logic             slot_vld,
    input logic [IDX_W-1:0] slot_idx,
    input logic             slot_sof,
    input logic             frm_err
);

    logic             seen;
    logic [IDX_W-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_idx <= '0;
        end else if (slot_vld) begin
            seen     <= 1'b1;
            last_idx <= slot_idx;
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!slot_vld && !frm_err);
        end
    end

    // R10
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> !slot_vld);

    // R10
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && seen) |-> (slot_idx == '0 || slot_idx == last_idx + 1'b1));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |-> (slot_idx <= nslots_m1));

    // R6
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && seen && last_idx == nslots_m1) |-> (slot_idx == '0 && slot_sof));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> frm_err);

endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nslots_m1 (nslots_m1),
    .slot_vld  (slot_vld),
    .slot_idx  (slot_idx),
    .slot_sof  (slot_sof),
    .frm_err   (frm_err)
);

// File: tb/test_tdm_frame_rx.sv
module test_tdm_frame_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] edge_sel = 2'b00;
    logic [6:0] nslots_m1 = '0;
    logic       line_clk = 1'b0;
    logic       line_sync = 1'b0;
    logic       line_data = 1'b0;
    logic       slot_vld;
    logic [7:0] slot_data;
    logic [6:0] slot_idx;
    logic       slot_sof;
    logic       frm_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  sq[$];
    bit  dq[$];
    logic [15:0] exp_q[$];
    bit  exp_err;
    bit  watch_on = 1'b0;
    bit  vld_prev = 1'b0;

    always #2.5 clk = ~clk;

    tdm_frame_rx i_tdm_frame_rx (
        .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .nslots_m1(nslots_m1),
        .line_clk(line_clk), .line_sync(line_sync), .line_data(line_data),
        .slot_vld(slot_vld), .slot_data(slot_data), .slot_idx(slot_idx),
        .slot_sof(slot_sof), .frm_err(frm_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference queue
    always @(negedge clk) begin
        if (watch_on) begin
            if (slot_vld && vld_prev)
                check(1'b0, "R10 slot_vld wider than one cycle", 1, 0);
            if (slot_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R8 unexpected slot", {slot_idx, slot_data}, -1);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(slot_data == e[7:0], "R4 slot byte", slot_data, e[7:0]);
                    check(slot_idx == e[14:8], "R6 slot index", slot_idx, e[14:8]);
                    check(slot_sof == e[15], "R5 start flag", slot_sof, e[15]);
                end
            end
        end
        vld_prev = slot_vld;
    end

    // behavioural reference: position within frame, counted in bits
    task automatic model(input int nslots);
        bit running = 0;
        int pos = 0;
        bit prev_s = 0;
        logic [7:0] acc = '0;
        exp_err = 0;
        exp_q.delete();
        for (int i = 0; i < sq.size(); i++) begin
            bit m;
            m = sq[i] && !prev_s;
            prev_s = sq[i];
            if (!running) begin
                if (!m) continue;
                running = 1;
                pos = 0;
            end else if (m && pos != 0) begin
                exp_err = 1;
                pos = 0;
            end else if (!m && pos == 0) begin
                exp_err = 1;
                running = 0;
                continue;
            end
            acc[7 - (pos % 8)] = dq[i];
            pos++;
            if (pos % 8 == 0) begin
                exp_q.push_back({(pos / 8 == 1), 7'(pos / 8 - 1), acc});
                if (pos == 8 * nslots) pos = 0;
            end
        end
    endtask

    task automatic add_bits(input int n, input bit sync_first);
        for (int i = 0; i < n; i++) begin
            sq.push_back(sync_first && i == 0);
            dq.push_back(1'($urandom()));
        end
    endtask

    task automatic add_frames(input int nslots, input int nfr);
        for (int f = 0; f < nfr; f++) add_bits(8 * nslots, 1'b1);
    endtask

    function automatic bit sbit(input int i);
        return (i >= 0 && i < sq.size()) ? sq[i] : 1'b0;
    endfunction

    function automatic bit dbit(input int i);
        return (i >= 0 && i < dq.size()) ? dq[i] : 1'b0;
    endfunction

    // one line period: low half then high half, 4 system clocks each
    task automatic line_call(input int k);
        int soff;
        soff = (edge_sel == 2'b10) ? 1 : 0;
        @(negedge clk);
        line_clk = 1'b0;
        if (!edge_sel[1]) line_sync = sbit(k + soff);
        if (!edge_sel[0]) line_data = dbit(k);
        repeat (4) @(negedge clk);
        line_clk = 1'b1;
        if (edge_sel[1]) line_sync = sbit(k + soff);
        if (edge_sel[0]) line_data = dbit(k);
        repeat (3) @(negedge clk);
    endtask

    task automatic scenario(input string tag, input logic [1:0] cfg, input int nslots);
        model(nslots);
        for (int k = 0; k <= sq.size(); k++) line_call(k);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, {tag, " slots missing"}, exp_q.size(), 0);
        check(frm_err == exp_err, {tag, " error flag"}, frm_err, exp_err);
        sq.delete();
        dq.delete();
    endtask

    task automatic restart(input logic [1:0] cfg, input int nslots);
        watch_on = 1'b0;
        rst_n = 1'b0;
        line_clk = 1'b0;
        line_sync = 1'b0;
        line_data = 1'b0;
        edge_sel = cfg;
        nslots_m1 = 7'(nslots - 1);
        exp_q.delete();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        watch_on = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, then data with no sync gives nothing
        restart(2'b00, 3);
        check(slot_vld == 1'b0, "R1 reset slot_vld", slot_vld, 0);
        check(frm_err == 1'b0, "R1 reset frm_err", frm_err, 0);
        add_bits(40, 1'b0);
        scenario("R1 hunt without sync", 2'b00, 3);

        // R2, R4, R5: each edge pairing with a few frames
        restart(2'b00, 3);
        add_bits(2, 1'b0); add_frames(3, 2); add_bits(4, 1'b1);
        scenario("R2 pairing 00", 2'b00, 3);

        restart(2'b01, 2);
        add_bits(2, 1'b0); add_frames(2, 3); add_bits(4, 1'b1);
        scenario("R2 pairing 01", 2'b01, 2);

        restart(2'b10, 4);
        add_bits(2, 1'b0); add_frames(4, 2); add_bits(4, 1'b1);
        scenario("R2 pairing 10", 2'b10, 4);

        // R6: single-slot frames
        restart(2'b11, 1);
        add_bits(2, 1'b0); add_frames(1, 4); add_bits(4, 1'b1);
        scenario("R6 one slot per frame", 2'b11, 1);

        // R6: largest frame
        restart(2'b00, 128);
        add_bits(2, 1'b0); add_frames(128, 1); add_bits(4, 1'b1);
        scenario("R6 128 slots per frame", 2'b00, 128);

        // R3: sync held high for three line periods counts once
        restart(2'b01, 2);
        add_bits(2, 1'b0);
        for (int f = 0; f < 2; f++) begin
            add_bits(16, 1'b1);
            sq[sq.size() - 15] = 1'b1;
            sq[sq.size() - 14] = 1'b1;
        end
        add_bits(4, 1'b1);
        scenario("R3 long sync", 2'b01, 2);

        // R7: sync in mid slot restarts the frame
        restart(2'b00, 3);
        add_bits(2, 1'b0); add_frames(3, 1);
        add_bits(11, 1'b1);
        add_frames(3, 1); add_bits(4, 1'b1);
        scenario("R7 misplaced sync", 2'b00, 3);

        // R8, R9: missing sync, hunt, resync, error stays set
        restart(2'b11, 2);
        add_bits(2, 1'b0); add_frames(2, 1);
        add_bits(20, 1'b0);
        add_frames(2, 2); add_bits(4, 1'b1);
        scenario("R8 R9 missing sync", 2'b11, 2);
        check(frm_err == 1'b1, "R9 flag after clean frames", frm_err, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule